// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Store Model

This block is a synthesizable behavioural model of a small serial EEPROM with a 64 x 16 register array behind a three-wire port. A host drives chip select, a serial clock and a data input. The model answers on a data output with a separate output enable, so a tri-state pad can sit outside it. Chip select, serial clock and data input are synchronised into the system clock domain with equal depth. Edges are detected in that domain, so the serial clock has to run well below the system clock.

A command begins with a start bit. Then come a two-bit opcode and a six-bit address, both sent most significant bit first. The model serves four commands: read with address auto-increment, word write, and two commands that set or clear a write-enable latch. A write does not start until chip select falls after the last data bit. It then keeps the model busy for `WRITE_CYCLES` system clocks. While chip select is high during that time, the data output reports busy or ready.

Top module: `serial_eeprom_model`

## Requirements
- R1: After reset, do_oe_o is low, the write-enable latch is clear and every word reads as 16'hFFFF.
- R2: Serial data is taken on each serial clock rise while chip select is high. The first 1 after chip select rises is the start bit, and any 0s before it are ignored. do_oe_o is low whenever chip select is low.
- R3: Opcode 2'b10 is a read. On the rise that takes A0, the output drives a 0. Each of the next 16 rises then drives one data bit, D15 first.
- R4: When a read continues past D0 with chip select still high, the next rise drives D15 of the following address, and address 63 is followed by address 0.
- R5: Opcode 2'b01 is a write: six address bits and then 16 data bits. If the latch is set, the whole word is replaced when chip select falls after D0.
- R6: Opcode 2'b00 with address bits A5:A4 = 2'b11 sets the latch, and 2'b00 clears it. A write issued while the latch is clear leaves memory unchanged. Reads work in either state.
- R7: While a write is in progress and chip select is high, the output is driven 0. It is driven 1 once the write is done. The start bit of the next command returns the output to high impedance. The busy period lasts no more than WRITE_CYCLES system clocks.
- R8: A command sent while a write is in progress has no effect.
- R9: If chip select falls before a command is complete, the model returns to searching for a start bit, and memory and the latch are unchanged.
- R10: If a chip select fall and a serial clock rise land in the same system clock, the fall takes priority and the clock rise is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data input |
| do_o | output | 1 | Serial data or busy/ready status |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
Two events can land in the same system clock: the rise of the serial clock and the fall of chip select. Both pass through synchroniser chains of equal depth. The bench provokes the overlap on the final write of the address sweep by raising the serial clock and dropping chip select at the same instant after D0. The result is judged by whether that word is committed and whether the busy/ready status appears afterwards, as if the extra clock edge had never arrived.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_HUNT, ST_OPC, ST_ADDR, ST_RD, ST_WDAT, ST_ARM, ST_HOLD
  } eep_st_e;
  localparam logic [1:0] OP_EXT = 2'b00;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= '0;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] arr [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) arr[w] <= '1;
      else if (we_i && waddr_i == AW'(w)) arr[w] <= wdata_i;
    end
  end

  assign rdata_o = arr[raddr_i];
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int AW           = 6,
  parameter int DW           = 16,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          sk_s_i,
  input  logic          di_s_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          mem_we_o,
  output logic          do_o,
  output logic          do_oe_o,
  output logic          busy_o,
  output logic          wen_o,
  output logic          stat_o,
  output logic          drv_o,
  output logic          cs_fall_o
);
  localparam int CW  = $clog2(WRITE_CYCLES + 1);
  localparam int NW  = $clog2(DW) + 1;

  eep_st_e       st_q;
  logic          cs_q, sk_q;
  logic [NW-1:0] cnt_q;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] dat_q;
  logic          wen_q, stat_q, drv_q, dout_q;
  logic [CW-1:0] bcnt_q;
  logic          sk_rise, cs_fall, busy;

  assign sk_rise = sk_s_i & ~sk_q;
  assign cs_fall = cs_q & ~cs_s_i;
  assign busy    = bcnt_q != '0;
  assign mem_we_o = cs_fall && st_q == ST_ARM && wen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs_s_i;
      sk_q <= sk_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bcnt_q <= '0;
    else if (mem_we_o) bcnt_q <= CW'(WRITE_CYCLES);
    else if (busy) bcnt_q <= bcnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      cnt_q  <= '0;
      op_q   <= '0;
      addr_q <= '0;
      dat_q  <= '0;
      wen_q  <= 1'b0;
      stat_q <= 1'b0;
      drv_q  <= 1'b0;
      dout_q <= 1'b0;
    end else if (cs_fall) begin
      // chip select fall wins over a coincident clock rise
      st_q  <= ST_HUNT;
      drv_q <= 1'b0;
      if (mem_we_o) stat_q <= 1'b1;
    end else if (cs_s_i && sk_rise) begin
      unique case (st_q)
        ST_HUNT: if (di_s_i && !busy) begin
          st_q   <= ST_OPC;
          cnt_q  <= '0;
          stat_q <= 1'b0;
        end
        ST_OPC: begin
          op_q  <= {op_q[0], di_s_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == NW'(1)) begin
            st_q  <= ST_ADDR;
            cnt_q <= '0;
          end
        end
        ST_ADDR: begin
          addr_q <= {addr_q[AW-2:0], di_s_i};
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == NW'(AW-1)) begin
            cnt_q <= '0;
            case (op_q)
              OP_RD: begin
                st_q   <= ST_RD;
                drv_q  <= 1'b1;
                dout_q <= 1'b0;
              end
              OP_WR:  st_q <= ST_WDAT;
              OP_EXT: begin
                st_q <= ST_HOLD;
                if (addr_q[AW-2:AW-3] == 2'b11) wen_q <= 1'b1;
                else if (addr_q[AW-2:AW-3] == 2'b00) wen_q <= 1'b0;
              end
              default: st_q <= ST_HOLD;
            endcase
          end
        end
        ST_RD: begin
          dout_q <= rdata_i[DW-1-int'(cnt_q)];
          if (cnt_q == NW'(DW-1)) begin
            cnt_q  <= '0;
            addr_q <= addr_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WDAT: begin
          dat_q <= {dat_q[DW-2:0], di_s_i};
          if (cnt_q == NW'(DW-1)) st_q <= ST_ARM;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign addr_o    = addr_q;
  assign wdata_o   = dat_q;
  assign do_oe_o   = cs_s_i && (drv_q || stat_q);
  assign do_o      = stat_q ? ~busy : dout_q;
  assign busy_o    = busy;
  assign wen_o     = wen_q;
  assign stat_o    = stat_q;
  assign drv_o     = drv_q;
  assign cs_fall_o = cs_fall;
endmodule

// File: rtl/serial_eeprom_model.sv
module serial_eeprom_model #(
  parameter int AW           = 6,
  parameter int DW           = 16,
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  logic [2:0]    pins_s;
  logic          cs_s, sk_s, di_s;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          mem_we, busy, wen, stat, drv, cs_fall;

  eep_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({cs_i, sk_i, di_i}), .q_o(pins_s)
  );
  assign {cs_s, sk_s, di_s} = pins_s;

  eep_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mem_we),
    .waddr_i(addr), .wdata_i(wdata), .raddr_i(addr), .rdata_o(rdata)
  );

  eep_ctrl #(.AW(AW), .DW(DW), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cs_s_i(cs_s), .sk_s_i(sk_s), .di_s_i(di_s), .rdata_i(rdata),
    .addr_o(addr), .wdata_o(wdata), .mem_we_o(mem_we),
    .do_o(do_o), .do_oe_o(do_oe_o), .busy_o(busy), .wen_o(wen),
    .stat_o(stat), .drv_o(drv), .cs_fall_o(cs_fall)
  );
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
  parameter int WRITE_CYCLES = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s,
  input logic do_o,
  input logic do_oe_o,
  input logic busy,
  input logic stat,
  input logic mem_we,
  input logic wen,
  input logic drv,
  input logic cs_fall
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else run_q <= 0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_ni) p_busy_len_r7: assert (run_q <= WRITE_CYCLES)
      else $error("busy longer than write time");
  end

  p_hiz_cs_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |-> !do_oe_o);
  p_dummy_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv) |-> (do_oe_o && !do_o));
  p_we_needs_wen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> wen);
  p_we_on_cs_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> cs_fall);
  p_busy_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && stat && cs_s) |-> (do_oe_o && !do_o));
  p_no_we_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !mem_we);
  p_busy_from_we_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(mem_we));
endmodule

bind serial_eeprom_model eep_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s(cs_s), .do_o(do_o),
  .do_oe_o(do_oe_o), .busy(busy), .stat(stat), .mem_we(mem_we),
  .wen(wen), .drv(drv), .cs_fall(cs_fall)
);

// File: tb/serial_eeprom_model_tb.sv
module serial_eeprom_model_tb;
  localparam int WC = 500;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout, doe;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  serial_eeprom_model #(.WRITE_CYCLES(WC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(dout), .do_oe_o(doe)
  );

  function automatic logic [15:0] pat(int a);
    return 16'((a * 16'h0405) ^ 16'hA5C3);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic o, output logic oe);
    di = b;
    wclk(8);
    sk = 1'b1;
    wclk(8);
    o = dout;
    oe = doe;
    sk = 1'b0;
  endtask

  task automatic send(input int val, input int n);
    logic o, oe;
    for (int i = n - 1; i >= 0; i--) bit_io(val[i], o, oe);
  endtask

  task automatic cs_up();
    cs = 1'b1;
    wclk(4);
  endtask

  task automatic cs_down();
    cs = 1'b0;
    di = 1'b0;
    wclk(8);
  endtask

  task automatic read_seq(input int addr, input int nwords, input string req);
    logic o, oe;
    logic [15:0] w;
    cs_up();
    send(3'b110, 3);
    send(addr >> 1, 5);
    bit_io(addr[0], o, oe);
    chk(oe && !o, "R3 dummy", {oe, o}, 2);
    for (int k = 0; k < nwords; k++) begin
      for (int b = 15; b >= 0; b--) begin
        bit_io(1'b0, o, oe);
        w[b] = o;
      end
      chk(w == pat((addr + k) % 64) || 0, req, w, pat((addr + k) % 64));
    end
    cs_down();
  endtask

  task automatic read_one(input int addr, input logic [15:0] exp, input string req);
    logic o, oe;
    logic [15:0] w;
    cs_up();
    send(3'b110, 3);
    send(addr, 6);
    for (int b = 15; b >= 0; b--) begin
      bit_io(1'b0, o, oe);
      w[b] = o;
    end
    chk(w == exp, req, w, exp);
    cs_down();
  endtask

  task automatic write_cmd(input int addr, input logic [15:0] d);
    cs_up();
    send(3'b101, 3);
    send(addr, 6);
    send(d, 16);
  endtask

  task automatic wait_ready(input string req);
    int n;
    cs_up();
    wclk(4);
    chk(doe && !dout, req, {doe, dout}, 2);
    n = 0;
    while (!dout && n < 4 * WC) begin
      wclk(1);
      n++;
    end
    chk(doe && dout && n < WC, req, n, WC);
  endtask

  task automatic ext_cmd(input logic [1:0] sel);
    cs_up();
    send(3'b100, 3);
    send({sel, 4'b1010}, 6);
    cs_down();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic o, oe;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    chk(!doe, "R1 reset oe", doe, 0);
    // leading zeros then a read of an untouched word
    cs_up();
    send(3'b000, 3);
    send(3'b110, 3);
    send(5, 6);
    for (int b = 0; b < 16; b++) bit_io(1'b0, o, oe);
    chk(oe && o, "R2 R1 start after zeros, erased word", {oe, o}, 3);
    cs_down();
    chk(!doe, "R2 hiz cs low", doe, 0);

    // write while latch clear: no effect
    write_cmd(3, 16'h1234);
    cs_down();
    read_one(3, 16'hFFFF, "R6 write ignored when disabled");

    ext_cmd(2'b11);
    for (int a = 0; a < 64; a++) begin
      write_cmd(a, pat(a));
      if (a == 63) begin
        wclk(8);
        sk = 1'b1;
        cs = 1'b0;   // same instant as the clock rise
        wclk(8);
        sk = 1'b0;
      end else begin
        cs_down();
      end
      wait_ready(a == 63 ? "R10 R7 coincident edge" : "R5 R7 status");
      cs_down();
    end
    read_seq(0, 65, "R5 R4 full sweep with wrap");
    read_seq(61, 6, "R4 wrap 63 to 0");

    // cancel partway through a write
    cs_up();
    send(3'b101, 3);
    send(7, 6);
    send(16'h00, 3);
    cs_down();
    read_one(7, pat(7), "R9 cancelled write");

    // command during busy is ignored
    write_cmd(9, 16'h0F0F);
    cs_down();
    cs_up();
    send(3'b101, 3);
    send(10, 6);
    send(16'h0000, 16);
    wait_ready("R8 busy status");
    cs_down();
    read_one(9, 16'h0F0F, "R9 R5 latch kept after cancel");
    read_one(10, pat(10), "R8 ignored during busy");

    // ready status returns to hi-z at next start bit, then disable
    write_cmd(12, 16'hBEEF);
    cs_down();
    wait_ready("R7 status");
    bit_io(1'b1, o, oe);
    wclk(2);
    chk(!doe, "R7 hiz after start bit", doe, 0);
    send(2'b00, 2);
    send(6'b001010, 6);
    cs_down();
    write_cmd(11, 16'h0000);
    cs_down();
    read_one(11, pat(11), "R6 disable blocks write");
    read_one(12, 16'hBEEF, "R5 word replaced");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule